// File: doc/BRIEF.md
# Two-Level Register Rename Unit

This unit renames the architectural registers of decoded instructions in two steps. A destination first receives a virtual-physical tag. A real physical register is bound to that tag only when the instruction produces its result. Physical registers are therefore not held by instructions that are still in flight. A general map table holds one entry per logical register: the latest tag, the latest physical register and a valid bit. A binding table holds one entry per tag and records the physical register that the tag was last bound to.

Decode presents one instruction per cycle, with two logical sources and one logical destination. In the same cycle, as a combinational answer, the unit returns the renamed sources with their ready flags, the new tag for the destination, and the tag the destination previously held, which the reorder buffer keeps. A completion port binds a fresh physical register to a finished tag. A rollback port restores a saved tag to a logical register. A release port returns a committed-over tag, and its physical register if it has one, to the free pools. Both pools hand out their lowest-numbered free entry.

Top module: `rn_vp_rename`

## Requirements
- R1: After reset, logical register i reads as physical register i with its ready flag set, tags 0 to LOG_REGS-1 are in use and the rest are free, and physical registers LOG_REGS to PHYS_REGS-1 are free.
- R2: A source whose map entry is valid is returned as its physical register number with ready = 1. Otherwise it is returned as its tag with ready = 0.
- R3: An accepted decode gives the destination the lowest-numbered free tag. It outputs the tag that the destination previously held, and leaves the destination entry holding the new tag with its valid bit cleared.
- R4: Sources are looked up before the destination of the same instruction is written, so a source equal to the destination sees the older mapping.
- R5: An accepted completion binds the lowest-numbered free physical register to the completing tag and outputs that number. If the logical entry still holds that tag, later reads of the entry return the physical register as ready.
- R6: A completion whose tag no longer matches the logical entry leaves the entry unchanged. Later reads still return the newer tag as not ready.
- R7: A rollback writes the saved tag into the logical entry. If that tag has a physical binding, the entry takes that register with the valid bit set. Otherwise the valid bit is cleared.
- R8: With no free tag, the decode ready output is low and a presented decode changes nothing.
- R9: With no free physical register, the completion ready output is low and a presented completion changes nothing.
- R10: A release returns the tag to the tag pool and, if the tag is bound, returns its physical register to the physical pool. Both can be allocated again from the next cycle.
- R11: During a rollback cycle both the decode ready and the completion ready outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode request |
| dec_src0 | input | LW | First logical source |
| dec_src1 | input | LW | Second logical source |
| dec_dst | input | LW | Logical destination |
| dec_ready | output | 1 | Decode can be accepted |
| dec_src0_tag | output | TW | Renamed first source |
| dec_src0_rdy | output | 1 | First source is a physical register |
| dec_src1_tag | output | TW | Renamed second source |
| dec_src1_rdy | output | 1 | Second source is a physical register |
| dec_dst_vp | output | VW | New tag for the destination |
| dec_prev_vp | output | VW | Tag the destination held before |
| cmp_valid | input | 1 | Completion request |
| cmp_vp | input | VW | Completing tag |
| cmp_log | input | LW | Logical destination of the completing instruction |
| cmp_ready | output | 1 | Completion can be accepted |
| cmp_phys | output | PW | Physical register bound to the completing tag |
| rb_valid | input | 1 | Rollback request |
| rb_log | input | LW | Logical register to restore |
| rb_vp | input | VW | Saved tag to restore |
| rel_valid | input | 1 | Release request |
| rel_vp | input | VW | Tag being released |

## Verification
The assertions assume that the environment releases only tags that are in use, never the same tag twice, and never a tag that is still the current mapping or still awaiting completion. They also assume that a completion names an outstanding tag and is not released in the same cycle. The random stimulus keeps within these limits. It completes only tags it has recorded as outstanding. It releases only previous tags that are already bound, and it removes each one from its list when it is released. Rollbacks appear only in directed sequences, and the state is reset before random traffic starts.

// File: rtl/rn_pkg.sv
package rn_pkg;
    parameter int LOG_REGS  = 8;
    parameter int VP_TAGS   = 16;
    parameter int PHYS_REGS = 12;

    localparam int LW = $clog2(LOG_REGS);
    localparam int VW = $clog2(VP_TAGS);
    localparam int PW = $clog2(PHYS_REGS);
    localparam int TW = (VW > PW) ? VW : PW;

    typedef struct packed {
        logic [VW-1:0] vp;
        logic [PW-1:0] phys;
        logic          valid;
    } gmt_entry_t;

    function automatic logic [TW-1:0] rename_src(gmt_entry_t e);
        return e.valid ? TW'(e.phys) : TW'(e.vp);
    endfunction
endpackage

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
    parameter int N          = 16,
    parameter int RESET_USED = 8,
    parameter int IW         = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_en,
    input  logic          rel_en,
    input  logic [IW-1:0] rel_idx,
    output logic          avail,
    output logic [IW-1:0] grant
);
    logic [N-1:0] free_q;
    logic [N-1:0] free_d;

    always_comb begin
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_q[i]) grant = IW'(i);
        end
        avail = |free_q;
    end

    always_comb begin
        free_d = free_q;
        if (alloc_en) free_d[grant] = 1'b0;
        if (rel_en)   free_d[rel_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) free_q[i] <= (i >= RESET_USED);
        end else begin
            free_q <= free_d;
        end
    end

    // R10
    rel_legal_chk: assert property (@(posedge clk) disable iff (rst)
        rel_en |-> !free_q[rel_idx]);

    // R8
    alloc_avail_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> avail);
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table
    import rn_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          dec_we,
    input  logic [LW-1:0] dec_log,
    input  logic [VW-1:0] dec_vp,
    input  logic          cmp_we,
    input  logic [LW-1:0] cmp_log,
    input  logic [VW-1:0] cmp_vp,
    input  logic [PW-1:0] cmp_phys,
    input  logic          rb_we,
    input  logic [LW-1:0] rb_log,
    input  logic [VW-1:0] rb_vp,
    input  logic [PW-1:0] rb_phys,
    input  logic          rb_bound,
    output gmt_entry_t    tbl [LOG_REGS]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LOG_REGS; i++) begin
                tbl[i].vp    <= VW'(i);
                tbl[i].phys  <= PW'(i);
                tbl[i].valid <= 1'b1;
            end
        end else begin
            for (int i = 0; i < LOG_REGS; i++) begin
                if (rb_we && rb_log == LW'(i)) begin
                    tbl[i].vp    <= rb_vp;
                    tbl[i].phys  <= rb_phys;
                    tbl[i].valid <= rb_bound;
                end else if (dec_we && dec_log == LW'(i)) begin
                    tbl[i].vp    <= dec_vp;
                    tbl[i].valid <= 1'b0;
                end else if (cmp_we && cmp_log == LW'(i) && tbl[i].vp == cmp_vp) begin
                    tbl[i].phys  <= cmp_phys;
                    tbl[i].valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rn_vp_rename.sv
module rn_vp_rename
    import rn_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          dec_valid,
    input  logic [LW-1:0] dec_src0,
    input  logic [LW-1:0] dec_src1,
    input  logic [LW-1:0] dec_dst,
    output logic          dec_ready,
    output logic [TW-1:0] dec_src0_tag,
    output logic          dec_src0_rdy,
    output logic [TW-1:0] dec_src1_tag,
    output logic          dec_src1_rdy,
    output logic [VW-1:0] dec_dst_vp,
    output logic [VW-1:0] dec_prev_vp,
    input  logic          cmp_valid,
    input  logic [VW-1:0] cmp_vp,
    input  logic [LW-1:0] cmp_log,
    output logic          cmp_ready,
    output logic [PW-1:0] cmp_phys,
    input  logic          rb_valid,
    input  logic [LW-1:0] rb_log,
    input  logic [VW-1:0] rb_vp,
    input  logic          rel_valid,
    input  logic [VW-1:0] rel_vp
);
    gmt_entry_t    tbl [LOG_REGS];
    logic [PW-1:0] pmt_phys  [VP_TAGS];
    logic          pmt_bound [VP_TAGS];

    logic          vp_avail, ph_avail, dec_fire, cmp_fire, ph_rel;
    logic [VW-1:0] vp_grant;
    logic [PW-1:0] ph_grant;

    assign dec_ready = vp_avail && !rb_valid;
    assign cmp_ready = ph_avail && !rb_valid;
    assign dec_fire  = dec_valid && dec_ready;
    assign cmp_fire  = cmp_valid && cmp_ready;
    assign ph_rel    = rel_valid && pmt_bound[rel_vp];

    assign dec_src0_tag = rename_src(tbl[dec_src0]);
    assign dec_src0_rdy = tbl[dec_src0].valid;
    assign dec_src1_tag = rename_src(tbl[dec_src1]);
    assign dec_src1_rdy = tbl[dec_src1].valid;
    assign dec_dst_vp   = vp_grant;
    assign dec_prev_vp  = tbl[dec_dst].vp;
    assign cmp_phys     = ph_grant;

    rn_free_pool #(.N(VP_TAGS), .RESET_USED(LOG_REGS), .IW(VW)) u_vp_pool (
        .clk(clk), .rst(rst), .alloc_en(dec_fire), .rel_en(rel_valid),
        .rel_idx(rel_vp), .avail(vp_avail), .grant(vp_grant)
    );

    rn_free_pool #(.N(PHYS_REGS), .RESET_USED(LOG_REGS), .IW(PW)) u_ph_pool (
        .clk(clk), .rst(rst), .alloc_en(cmp_fire), .rel_en(ph_rel),
        .rel_idx(pmt_phys[rel_vp]), .avail(ph_avail), .grant(ph_grant)
    );

    rn_map_table u_gmt (
        .clk(clk), .rst(rst),
        .dec_we(dec_fire), .dec_log(dec_dst), .dec_vp(vp_grant),
        .cmp_we(cmp_fire), .cmp_log(cmp_log), .cmp_vp(cmp_vp), .cmp_phys(ph_grant),
        .rb_we(rb_valid), .rb_log(rb_log), .rb_vp(rb_vp),
        .rb_phys(pmt_phys[rb_vp]), .rb_bound(pmt_bound[rb_vp]),
        .tbl(tbl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < VP_TAGS; i++) begin
                pmt_phys[i]  <= (i < LOG_REGS) ? PW'(i) : '0;
                pmt_bound[i] <= (i < LOG_REGS);
            end
        end else begin
            for (int i = 0; i < VP_TAGS; i++) begin
                if (cmp_fire && cmp_vp == VW'(i)) begin
                    pmt_phys[i]  <= ph_grant;
                    pmt_bound[i] <= 1'b1;
                end else if ((rel_valid && rel_vp == VW'(i)) ||
                             (dec_fire && vp_grant == VW'(i))) begin
                    pmt_bound[i] <= 1'b0;
                end
            end
        end
    end

    // R3
    dst_map_chk: assert property (@(posedge clk) disable iff (rst)
        dec_fire |=> (tbl[$past(dec_dst)].vp == $past(dec_dst_vp)) && !tbl[$past(dec_dst)].valid);

    // R5
    bind_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_fire |=> pmt_bound[$past(cmp_vp)] && (pmt_phys[$past(cmp_vp)] == $past(cmp_phys)));

    // R6
    stale_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_fire && !rb_valid && tbl[cmp_log].vp != cmp_vp && !(dec_fire && dec_dst == cmp_log))
        |=> tbl[$past(cmp_log)] == $past(tbl[cmp_log]));

    // R7
    rb_restore_chk: assert property (@(posedge clk) disable iff (rst)
        rb_valid |=> tbl[$past(rb_log)].vp == $past(rb_vp));

    // R11
    rb_block_chk: assert property (@(posedge clk) disable iff (rst)
        rb_valid |-> !dec_ready && !cmp_ready);
endmodule

// File: tb/sim_rn_vp_rename.sv
module sim_rn_vp_rename;
    import rn_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          d_v, c_v, r_v, l_v;
    logic [LW-1:0] d_s0, d_s1, d_d, c_log, r_log;
    logic [VW-1:0] c_vp, r_vp, l_vp;
    logic          dec_ready, dec_src0_rdy, dec_src1_rdy, cmp_ready;
    logic [TW-1:0] dec_src0_tag, dec_src1_tag;
    logic [VW-1:0] dec_dst_vp, dec_prev_vp;
    logic [PW-1:0] cmp_phys;

    rn_vp_rename u0 (
        .clk(clk), .rst(rst),
        .dec_valid(d_v), .dec_src0(d_s0), .dec_src1(d_s1), .dec_dst(d_d),
        .dec_ready(dec_ready), .dec_src0_tag(dec_src0_tag), .dec_src0_rdy(dec_src0_rdy),
        .dec_src1_tag(dec_src1_tag), .dec_src1_rdy(dec_src1_rdy),
        .dec_dst_vp(dec_dst_vp), .dec_prev_vp(dec_prev_vp),
        .cmp_valid(c_v), .cmp_vp(c_vp), .cmp_log(c_log), .cmp_ready(cmp_ready), .cmp_phys(cmp_phys),
        .rb_valid(r_v), .rb_log(r_log), .rb_vp(r_vp),
        .rel_valid(l_v), .rel_vp(l_vp)
    );

    int checks = 0, fails = 0;
    string lab = "";
    int m_vp [LOG_REGS], m_ph [LOG_REGS];
    bit m_v [LOG_REGS];
    int m_pmt [VP_TAGS];
    bit m_bnd [VP_TAGS], m_vfree [VP_TAGS], m_pfree [PHYS_REGS];
    bit last_dfire, last_cfire;
    int last_nv, last_prev;

    task automatic chk(string r, string w, int a, int e);
        checks++;
        if (a != e) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", r, w, a, e);
        end
    endtask

    function automatic int low_v();
        for (int i = 0; i < VP_TAGS; i++) if (m_vfree[i]) return i;
        return -1;
    endfunction

    function automatic int low_p();
        for (int i = 0; i < PHYS_REGS; i++) if (m_pfree[i]) return i;
        return -1;
    endfunction

    function automatic int exp_tag(int l);
        return m_v[l] ? m_ph[l] : m_vp[l];
    endfunction

    task automatic idle();
        d_v = 0; c_v = 0; r_v = 0; l_v = 0;
        d_s0 = 0; d_s1 = 0; d_d = 0; c_vp = 0; c_log = 0; r_log = 0; r_vp = 0; l_vp = 0;
    endtask

    task automatic do_reset();
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < LOG_REGS; i++) begin
            m_vp[i] = i; m_ph[i] = i; m_v[i] = 1;
        end
        for (int i = 0; i < VP_TAGS; i++) begin
            m_pmt[i] = (i < LOG_REGS) ? i : 0;
            m_bnd[i] = (i < LOG_REGS);
            m_vfree[i] = (i >= LOG_REGS);
        end
        for (int i = 0; i < PHYS_REGS; i++) m_pfree[i] = (i >= LOG_REGS);
    endtask

    task automatic cycle();
        int nv, np, ovp, opmt;
        bit edr, ecr, obnd;
        #1;
        nv = low_v(); np = low_p();
        edr = (nv >= 0) && !r_v;
        ecr = (np >= 0) && !r_v;
        chk(r_v ? "R11" : "R8", "dec_ready", int'(dec_ready), int'(edr));
        chk(r_v ? "R11" : "R9", "cmp_ready", int'(cmp_ready), int'(ecr));
        if (d_v && edr) begin
            chk(lab != "" ? lab : (d_s0 == d_d ? "R4" : "R2"), "src0 tag", int'(dec_src0_tag), exp_tag(d_s0));
            chk(lab != "" ? lab : (d_s0 == d_d ? "R4" : "R2"), "src0 rdy", int'(dec_src0_rdy), int'(m_v[d_s0]));
            chk(lab != "" ? lab : (d_s1 == d_d ? "R4" : "R2"), "src1 tag", int'(dec_src1_tag), exp_tag(d_s1));
            chk(lab != "" ? lab : (d_s1 == d_d ? "R4" : "R2"), "src1 rdy", int'(dec_src1_rdy), int'(m_v[d_s1]));
            chk(lab != "" ? lab : "R3", "dst vp", int'(dec_dst_vp), nv);
            chk(lab != "" ? lab : "R3", "prev vp", int'(dec_prev_vp), m_vp[d_d]);
        end
        if (c_v && ecr) chk(lab != "" ? lab : "R5", "cmp phys", int'(cmp_phys), np);
        @(posedge clk);
        last_dfire = d_v && edr;
        last_cfire = c_v && ecr;
        obnd = m_bnd[l_vp]; opmt = m_pmt[l_vp];
        ovp = m_vp[c_log];
        if (r_v) begin
            m_vp[r_log] = r_vp; m_ph[r_log] = m_pmt[r_vp]; m_v[r_log] = m_bnd[r_vp];
        end
        if (last_dfire) begin
            last_nv = nv; last_prev = m_vp[d_d];
            m_vfree[nv] = 0; m_bnd[nv] = 0;
            m_vp[d_d] = nv; m_v[d_d] = 0;
        end
        if (last_cfire) begin
            m_pfree[np] = 0;
            m_pmt[c_vp] = np; m_bnd[c_vp] = 1;
            if (ovp == c_vp && !(last_dfire && d_d == c_log)) begin
                m_ph[c_log] = np; m_v[c_log] = 1;
            end
        end
        if (l_v) begin
            m_vfree[l_vp] = 1;
            if (obnd) m_pfree[opmt] = 1;
            if (!(last_cfire && c_vp == l_vp)) m_bnd[l_vp] = 0;
        end
        @(negedge clk);
        idle();
    endtask

    task automatic dec(int s0, int s1, int d);
        d_v = 1; d_s0 = LW'(s0); d_s1 = LW'(s1); d_d = LW'(d);
    endtask

    task automatic cmp(int vp, int l);
        c_v = 1; c_vp = VW'(vp); c_log = LW'(l);
    endtask

    bit done = 0;
    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int pv [$], pl [$], rq [$];
        int ci, ri;
        void'($urandom(32'd7));
        do_reset();

        // R1: reset mapping
        lab = "R1"; dec(0, 7, 3); cycle();
        lab = "";
        dec(3, 3, 3); cycle();                 // R4: sources see VP 8
        cmp(8, 3); cycle();                    // stale completion, phys 8
        lab = "R6"; dec(3, 1, 5); cycle();     // R6: still VP 9 not ready
        lab = "R5"; cmp(9, 3); cycle();
        dec(3, 0, 5); cycle();                 // R5: phys 9 ready
        lab = "R11"; r_v = 1; r_log = 3; r_vp = 8; dec(1, 2, 4); cmp(10, 5); cycle();
        lab = "R7"; dec(3, 6, 2); cycle();     // R7: bound tag restores phys 8
        r_v = 1; r_log = 6; r_vp = 11; cycle();
        dec(6, 3, 1); cycle();                 // R7: unbound tag, not ready

        do_reset();
        lab = "R8";
        for (int k = 0; k < VP_TAGS - LOG_REGS; k++) begin dec(0, 1, 0); cycle(); end
        dec(2, 3, 4); cycle();                 // R8: refused
        dec(4, 4, 1); l_v = 1; l_vp = 0; cycle();
        lab = "R10"; dec(4, 1, 2); cycle();    // R10: VP 0 reused, R8 state unchanged
        cmp(8, 0); cycle();                    // R10: phys 0 reused
        lab = "R9";
        for (int k = 9; k < 13; k++) begin cmp(k, 0); cycle(); end
        cmp(13, 0); cycle();                   // R9: refused
        dec(0, 2, 5); l_v = 1; l_vp = 9; cycle();
        dec(0, 2, 6); cycle();
        lab = "";

        do_reset();
        for (int it = 0; it < 4000; it++) begin
            ci = -1; ri = -1;
            if ($urandom % 10 < 6) dec($urandom % LOG_REGS, $urandom % LOG_REGS, $urandom % LOG_REGS);
            if (pv.size() > 0 && ($urandom % 2) == 1) begin
                ci = $urandom % pv.size();
                cmp(pv[ci], pl[ci]);
            end
            if (($urandom % 10) < 4) begin
                for (int j = 0; j < rq.size(); j++) begin
                    if (ri < 0 && m_bnd[rq[j]] && !(ci >= 0 && rq[j] == pv[ci])) ri = j;
                end
                if (ri >= 0) begin l_v = 1; l_vp = VW'(rq[ri]); end
            end
            cycle();
            if (ri >= 0) rq.delete(ri);
            if (last_cfire) begin pv.delete(ci); pl.delete(ci); end
            if (last_dfire) begin
                pv.push_back(last_nv); pl.push_back(int'(d_d_hold(last_nv)));
                rq.push_back(last_prev);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    int dst_of [VP_TAGS];
    always @(posedge clk) if (!rst && d_v && dec_ready) dst_of[dec_dst_vp] = int'(d_d);

    function automatic int d_d_hold(int vp);
        return dst_of[vp];
    endfunction
endmodule